// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a page directory entry and, for small pages, a page table entry from memory through a single 32-bit read/write port. It checks the access rights held in those entries against the request's user and write flags, sets the accessed and dirty bits in memory when they need to change, and finishes with either a physical address plus permission bits or a fault and its error code.

A request is a one-cycle pulse on `req_valid` while the walker is idle. The walker then owns the memory port and issues at most four accesses: directory read, optional directory write-back, table read, optional table write-back. It moves to the next access in the cycle the memory acknowledges. `done` pulses for one cycle when the result outputs are valid. When paging is off, no memory access is made and the result appears one cycle after the request.

Top module: `pt_walker`

## Requirements
- R1: With `pg_en` low, a request completes one cycle later with `phys_addr` equal to `req_lin`, no fault, `perm_w` and `perm_u` both 1, and no memory access.
- R2: The directory entry is read at `((dir_base & 0xFFFFF000) + 4*req_lin[31:22]) & a20_mask`.
- R3: The table entry is read at `((pde & 0xFFFFF000) + 4*req_lin[21:12]) & a20_mask`.
- R4: `a20_mask` is ANDed into every entry address and into the page frame base. The page offset is added after masking.
- R5: An entry whose present bit (bit 0) is clear ends the walk with a fault. `fault_code` is {user, write, 0}, with bit 0 = protection, bit 1 = write and bit 2 = user.
- R6: A directory entry with bit 7 set maps a 4 MiB page only while `big_en` is 1. The physical address is then `(pde & 0xFFC00000 & a20_mask) | req_lin[21:0]`. With `big_en` at 0, the entry points to a page table as usual.
- R7: The effective user bit (bit 2) and read/write bit (bit 1) are the AND of both levels. A user access without the user bit faults, and so does a user write without the read/write bit. Either faults with `fault_code` {user, write, 1}.
- R8: A supervisor write to a read-only page faults only while `wp_en` is 1.
- R9: Write-backs happen only when a bit changes. Accessed (bit 5) is set only where it was clear. Dirty (bit 6) is set on the final entry only for a write where it was clear. The data written is the entry read with those bits set.
- R10: In a two-level walk, the directory write-back happens before the table entry is read.
- R11: `perm_w` is 1 only if the final entry is dirty after the walk. It also needs the effective read/write bit, or a supervisor request with `wp_en` at 0. `perm_u` is the effective user bit.
- R12: `done` is a single-cycle pulse. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request pulse, taken when idle |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| busy | output | 1 | Walk in progress |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Supervisor write-protect enable |
| big_en | input | 1 | 4 MiB page enable |
| dir_base | input | 32 | Page directory base |
| a20_mask | input | 32 | Address mask applied to memory addresses |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete this cycle |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | {user, write, protection} |
| phys_addr | output | 32 | Translated address |
| perm_w | output | 1 | Write may bypass the walk |
| perm_u | output | 1 | User access permitted |

## Verification
The embedded properties assume that `pg_en`, `wp_en`, `big_en`, `dir_base` and `a20_mask` stay still during a walk, that memory read data is valid in the cycle `mem_ack` is high, and that the request flags are sampled only when the walker is idle. The bench changes control inputs only between walks. Its memory model acknowledges every access in the cycle it is requested, and it drives `req_valid` as short pulses, including one deliberately placed mid-walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic        req_user,
  output logic        busy,
  input  logic        pg_en,
  input  logic        wp_en,
  input  logic        big_en,
  input  logic [31:0] dir_base,
  input  logic [31:0] a20_mask,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_code,
  output logic [31:0] phys_addr,
  output logic        perm_w,
  output logic        perm_u
);
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_U  = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;
  localparam logic [31:0] FRAME4K = 32'hFFFF_F000;
  localparam logic [31:0] FRAME4M = 32'hFFC0_0000;

  typedef enum logic [2:0] {S_IDLE, S_RDD, S_WBD, S_RDT, S_WBT} st_t;

  st_t         st;
  logic [31:0] lin_q, pde_q, pte_q;
  logic        wr_q, us_q, big_q;

  logic [31:0] pde_addr, pte_addr, upd, frame;
  logic        is_big, u_eff, rw_eff, prot_fail, pw_calc;

  assign pde_addr = ((dir_base & FRAME4K) + {20'b0, lin_q[31:22], 2'b00}) & a20_mask;
  assign pte_addr = ((pde_q & FRAME4K) + {20'b0, lin_q[21:12], 2'b00}) & a20_mask;

  assign is_big    = mem_rdata[B_PS] & big_en;
  assign u_eff     = (st == S_RDT) ? (pde_q[B_U]  & mem_rdata[B_U])  : mem_rdata[B_U];
  assign rw_eff    = (st == S_RDT) ? (pde_q[B_RW] & mem_rdata[B_RW]) : mem_rdata[B_RW];
  assign prot_fail = (us_q & ~u_eff) | (us_q & wr_q & ~rw_eff) | (~us_q & wr_q & wp_en & ~rw_eff);
  assign upd       = mem_rdata | (32'd1 << B_A) | ({31'd0, wr_q} << B_D);
  assign pw_calc   = upd[B_D] & (rw_eff | (~us_q & ~wp_en));
  assign frame     = (st == S_RDT) ? (((mem_rdata & FRAME4K) & a20_mask) | {20'b0, lin_q[11:0]})
                                   : (((mem_rdata & FRAME4M) & a20_mask) | {10'b0, lin_q[21:0]});

  assign busy      = (st != S_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == S_WBD) || (st == S_WBT);
  assign mem_addr  = (st == S_RDD || st == S_WBD) ? pde_addr : pte_addr;
  assign mem_wdata = (st == S_WBD) ? pde_q : pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; lin_q <= '0; pde_q <= '0; pte_q <= '0;
      wr_q <= 1'b0; us_q <= 1'b0; big_q <= 1'b0;
      done <= 1'b0; fault <= 1'b0; fault_code <= '0;
      phys_addr <= '0; perm_w <= 1'b0; perm_u <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q <= req_lin; wr_q <= req_write; us_q <= req_user;
          if (!pg_en) begin
            done <= 1'b1; fault <= 1'b0; fault_code <= '0;
            phys_addr <= req_lin; perm_w <= 1'b1; perm_u <= 1'b1;
          end else st <= S_RDD;
        end
        S_RDD: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= {us_q, wr_q, 1'b0}; st <= S_IDLE;
          end else if (is_big) begin
            if (prot_fail) begin
              done <= 1'b1; fault <= 1'b1; fault_code <= {us_q, wr_q, 1'b1}; st <= S_IDLE;
            end else begin
              fault <= 1'b0; fault_code <= '0;
              phys_addr <= frame; perm_w <= pw_calc; perm_u <= u_eff;
              big_q <= 1'b1;
              if (upd != mem_rdata) begin
                pde_q <= upd; st <= S_WBD;
              end else begin
                done <= 1'b1; st <= S_IDLE;
              end
            end
          end else begin
            big_q <= 1'b0;
            if (!mem_rdata[B_A]) begin
              pde_q <= mem_rdata | (32'd1 << B_A); st <= S_WBD;
            end else st <= S_RDT;
          end
        end
        S_WBD: if (mem_ack) begin
          if (big_q) begin
            done <= 1'b1; st <= S_IDLE;
          end else st <= S_RDT;
        end
        S_RDT: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= {us_q, wr_q, 1'b0}; st <= S_IDLE;
          end else if (prot_fail) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= {us_q, wr_q, 1'b1}; st <= S_IDLE;
          end else begin
            fault <= 1'b0; fault_code <= '0;
            phys_addr <= frame; perm_w <= pw_calc; perm_u <= u_eff;
            if (upd != mem_rdata) begin
              pte_q <= upd; st <= S_WBT;
            end else begin
              done <= 1'b1; st <= S_IDLE;
            end
          end
        end
        S_WBT: if (mem_ack) begin
          done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  wb_sets_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_A]);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  user_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && us_q) |-> perm_u);

  // R1
  identity_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid && !pg_en) |=> (done && !fault && phys_addr == $past(req_lin)));

  // R5
  code_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code[2:1] == {us_q, wr_q}));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [31:0] lin;
    logic        w;
    logic        u;
    logic        wp;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        f;
    logic [2:0]  code;
    logic [31:0] phys;
    logic        pw;
    logic        pu;
    logic [1:0]  nwr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [0:NV-1] = '{
    '{32'h0040_3123, 1'b0, 1'b1, 1'b0, 32'h0000_2007, 32'h0055_5007, 1'b0, 3'd0, 32'h0055_5123, 1'b0, 1'b1, 2'd2},
    '{32'h0040_3123, 1'b1, 1'b1, 1'b0, 32'h0000_2027, 32'h0055_5067, 1'b0, 3'd0, 32'h0055_5123, 1'b1, 1'b1, 2'd0},
    '{32'h0040_3123, 1'b0, 1'b1, 1'b0, 32'h0000_2003, 32'h0055_5007, 1'b1, 3'd5, 32'h0,         1'b0, 1'b0, 2'd1},
    '{32'h0040_3123, 1'b1, 1'b1, 1'b0, 32'h0000_2027, 32'h0055_5025, 1'b1, 3'd7, 32'h0,         1'b0, 1'b0, 2'd0},
    '{32'h0040_3123, 1'b1, 1'b0, 1'b0, 32'h0000_2006, 32'h0055_5007, 1'b1, 3'd2, 32'h0,         1'b0, 1'b0, 2'd0},
    '{32'h0040_3123, 1'b0, 1'b0, 1'b0, 32'h0000_2007, 32'h0000_0000, 1'b1, 3'd0, 32'h0,         1'b0, 1'b0, 2'd1},
    '{32'h0040_3123, 1'b1, 1'b0, 1'b0, 32'h0000_2025, 32'h0055_5021, 1'b0, 3'd0, 32'h0055_5123, 1'b1, 1'b0, 2'd1},
    '{32'h00C0_5ABC, 1'b1, 1'b0, 1'b0, 32'h0080_00A7, 32'h0000_0000, 1'b0, 3'd0, 32'h0080_5ABC, 1'b1, 1'b1, 2'd1},
    '{32'h0040_3123, 1'b1, 1'b0, 1'b1, 32'h0000_2025, 32'h0055_5021, 1'b1, 3'd3, 32'h0,         1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin = '0;
  logic pg_en = 1'b1, wp_en = 1'b0, big_en = 1'b1;
  logic [31:0] dir_base = 32'h0000_1000, a20_mask = 32'hFFFF_FFFF;
  logic busy, mem_req, mem_we, mem_ack, done, fault, perm_w, perm_u;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, phys_addr;
  logic [2:0] fault_code;

  logic [31:0] mem [0:4095];
  logic [31:0] log_addr [0:7];
  logic        log_we   [0:7];
  logic [31:0] log_dat  [0:7];
  int n_log = 0, n_wr = 0, n_done = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[13:2]];

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .busy(busy),
    .pg_en(pg_en), .wp_en(wp_en), .big_en(big_en), .dir_base(dir_base),
    .a20_mask(a20_mask), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .fault(fault), .fault_code(fault_code), .phys_addr(phys_addr),
    .perm_w(perm_w), .perm_u(perm_u)
  );

  always @(posedge clk) begin
    if (rst_n && done) n_done++;
    if (rst_n && mem_req) begin
      if (n_log < 8) begin
        log_addr[n_log] = mem_addr; log_we[n_log] = mem_we; log_dat[n_log] = mem_wdata;
      end
      n_log++;
      if (mem_we) begin
        mem[mem_addr[13:2]] = mem_wdata;
        n_wr++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  task automatic put(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[13:2]] = val;
  endtask

  task automatic walk(input logic [31:0] lin, input logic w, input logic u);
    n_log = 0; n_wr = 0;
    req_lin = lin; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!finished) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R12 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 paging off
    pg_en = 1'b0;
    walk(32'hDEAD_BEEF, 1'b1, 1'b1);
    chk("R1 done", {31'd0, done}, 32'd1);
    chk("R1 phys", phys_addr, 32'hDEAD_BEEF);
    chk("R1 perms", {30'd0, perm_w, perm_u}, 32'd3);
    chk("R1 no mem access", n_log, 0);
    pg_en = 1'b1;
    @(negedge clk);

    // vector table: R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      clear_mem();
      wp_en = VEC[v].wp;
      put(32'h1000 + {20'd0, VEC[v].lin[31:22], 2'b00}, VEC[v].pde);
      put(32'h2000 + {20'd0, VEC[v].lin[21:12], 2'b00}, VEC[v].pte);
      walk(VEC[v].lin, VEC[v].w, VEC[v].u);
      chk($sformatf("R5/R7/R8 v%0d done", v), {31'd0, done}, 32'd1);
      chk($sformatf("R5/R7/R8 v%0d fault", v), {31'd0, fault}, {31'd0, VEC[v].f});
      if (VEC[v].f)
        chk($sformatf("R5/R7/R8 v%0d code", v), {29'd0, fault_code}, {29'd0, VEC[v].code});
      else begin
        chk($sformatf("R6 v%0d phys", v), phys_addr, VEC[v].phys);
        chk($sformatf("R11 v%0d perm_w", v), {31'd0, perm_w}, {31'd0, VEC[v].pw});
        chk($sformatf("R7 v%0d perm_u", v), {31'd0, perm_u}, {31'd0, VEC[v].pu});
      end
      chk($sformatf("R9 v%0d writes", v), n_wr, {30'd0, VEC[v].nwr});
      @(negedge clk);
    end
    wp_en = 1'b0;

    // R2 R3 R9 R10 ordering and write data
    clear_mem();
    put(32'h1004, 32'h0000_2007);
    put(32'h200C, 32'h0055_5007);
    walk(32'h0040_3123, 1'b1, 1'b0);
    chk("R2 dir read addr", log_addr[0], 32'h0000_1004);
    chk("R10 dir writeback first", {31'd0, log_we[1]}, 32'd1);
    chk("R9 dir writeback data", log_dat[1], 32'h0000_2027);
    chk("R3 table read addr", log_addr[2], 32'h0000_200C);
    chk("R10 table read after dir write", {31'd0, log_we[2]}, 32'd0);
    chk("R9 table writeback data", log_dat[3], 32'h0055_5067);
    chk("R11 write after dirty set", {31'd0, perm_w}, 32'd1);
    @(negedge clk);

    // R4 A20 masking
    clear_mem();
    a20_mask = ~(32'd1 << 20);
    dir_base = 32'h0010_1000;
    put(32'h1004, 32'h0010_2027);
    put(32'h200C, 32'h0015_5027);
    walk(32'h0040_3123, 1'b0, 1'b0);
    chk("R4 dir addr masked", log_addr[0], 32'h0000_1004);
    chk("R4 table addr masked", log_addr[1], 32'h0000_200C);
    chk("R4 frame masked", phys_addr, 32'h0005_5123);
    a20_mask = 32'hFFFF_FFFF;
    dir_base = 32'h0000_1000;
    @(negedge clk);

    // R6 page-size bit ignored without big_en
    clear_mem();
    big_en = 1'b0;
    put(32'h1004, 32'h0000_20A7);
    put(32'h200C, 32'h0055_5027);
    walk(32'h0040_3123, 1'b0, 1'b0);
    chk("R6 two reads", n_log, 2);
    chk("R6 small-page phys", phys_addr, 32'h0055_5123);
    big_en = 1'b1;
    @(negedge clk);

    // R12 request while busy ignored
    clear_mem();
    put(32'h1004, 32'h0000_2027);
    put(32'h200C, 32'h0055_5027);
    n_log = 0;
    n_done = 0;
    req_lin = 32'h0040_3123; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_lin = 32'h00C0_5ABC; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 one completion", n_done, 1);
    chk("R12 first request result", phys_addr, 32'h0055_5123);
    chk("R12 no extra accesses", n_log, 2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule